// File: doc/BRIEF.md
# Vertical Video Timing Measurement Unit

This block measures the vertical timing of an incoming video stream in whole horizontal line periods. It takes a one-clock line tick together with a vertical sync level and an active-video level. At every tick it sorts the line into one of four phases: sync, back porch, active or front porch. It counts how long each phase lasts. When a phase ends, the finished length is reported to two consumers.

The first consumer is the measurement controller. After software sets a self-clearing run bit, it waits for a clean field start. It then tracks the lowest sync width, back porch and front porch over a fixed number of whole fields. When the run is complete it clears the run bit itself and raises a done flag. The second consumer is a previous-field shadow set. At each field start it captures the sync, back porch and front porch of the field that just ended, so that the two fields of an interlaced frame can be compared. A separate strobe clears that shadow set to zero.

A small byte-wide register port gives the run and reset controls and reads back all results. Results wider than a byte are split into low and high bytes. Reading a low byte freezes the matching high bits, so the two halves always belong to one value.

Phase state machine (`vtm_line_classifier`), sampled on each line tick:
- **PH_SYNC**: entered whenever vsync is high.
- **PH_BACK**: entered from PH_SYNC or kept from PH_BACK when the line has no vsync and no active video.
- **PH_ACTIVE**: entered on any line with active video and no vsync.
- **PH_FRONT**: entered from PH_ACTIVE, or kept from PH_FRONT, on a line with no vsync and no active video.
- Entering PH_SYNC from any other state marks a field start.

Run state machine (`vtm_min_ctrl`):
- **CT_IDLE**: moves to CT_ARM when a start is written.
- **CT_ARM**: moves to CT_RUN on the next field start.
- **CT_RUN**: a start goes back to CT_ARM. The field start that completes the last field goes to CT_IDLE and sets done.

Top module: `vert_timing_meas`

## Requirements
- R1: The sync width is the number of consecutive lines with vsync high, in line periods.
- R2: The back porch is the number of lines with both vsync and active low between the end of sync and the first active line. If no active line comes before the next sync, it runs up to that sync.
- R3: The front porch is the number of lines with both vsync and active low after the last active line and before the next sync.
- R4: Counts saturate instead of wrapping. Porches stop at 2047 and the sync width stops at 255.
- R5: Writing 1 to bit 0 of control address 0 sets the current minima to all ones (sync 255, porches 2047) and clears done. Bit 0 then reads 1.
- R6: After a start, phase lengths are ignored until the first field start. The run then covers NUM_FIELDS (default 4) complete fields. At the field start that ends the last field, bit 0 clears and done (bit 1 of address 0) sets.
- R7: During a run, each current result holds the lowest value measured for its phase.
- R8: At every field start, the previous-field registers take the sync, back porch and front porch of the field that just ended. The front porch reads 0 if that field had no active video.
- R9: Writing 1 to bit 2 of address 0 clears all previous-field registers to zero at once.
- R10: Addresses map as follows: 1 = current sync, 2/3 = current back porch low/high, 4/5 = current front porch low/high, 6 = previous sync, 7/8 = previous back porch low/high, 9/10 = previous front porch low/high. Each high byte holds bits 10..8, and bits 7..3 of it read 0. Reading a low byte latches the high bits that the next high-byte read returns.
- R11: With no active video, the previous back porch plus the previous sync width equals the total lines per field.
- R12: Read data appears one clock after the read strobe. Unmapped addresses 11..15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_tick | input | 1 | One-clock pulse per horizontal line |
| vsync | input | 1 | Vertical sync level, sampled on line_tick |
| vactive | input | 1 | Active-video level, sampled on line_tick |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one clock after bus_rd |

## Verification
A wrong phase in the classifier puts a line into the wrong count. This shows at the next field start as a previous-field value that is off by that line. A wrong run state or field counter makes the run bit clear one field early or late, and this is visible on the first control read after that field start. A minimum that is updated outside a run, or from the partial field before arming, leaves a current result below the smallest complete field. A high byte that is not latched shows as soon as the value changes between the low-byte read and the high-byte read.

// File: rtl/vtm_pkg.sv
package vtm_pkg;
    typedef enum logic [1:0] {PH_SYNC, PH_BACK, PH_ACTIVE, PH_FRONT} phase_e;
    typedef enum logic [1:0] {CT_IDLE, CT_ARM, CT_RUN} ctl_e;
endpackage

// File: rtl/vtm_line_classifier.sv
module vtm_line_classifier
    import vtm_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int SYN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_tick,
    input  logic             vsync,
    input  logic             vactive,
    output logic             emit_valid,
    output phase_e           emit_phase,
    output logic [CNT_W-1:0] emit_count,
    output logic [SYN_W-1:0] emit_sync,
    output logic             field_start
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] SYN_CAP = CNT_W'((1 << SYN_W) - 1);

    phase_e           ph_q, cls;
    logic [CNT_W-1:0] cnt_q;

    // classification of the current line
    always_comb begin
        if (vsync) begin
            cls = PH_SYNC;
        end else if (vactive) begin
            cls = PH_ACTIVE;
        end else begin
            unique case (ph_q)
                PH_ACTIVE, PH_FRONT: cls = PH_FRONT;
                PH_SYNC, PH_BACK:    cls = PH_BACK;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_BACK;
            cnt_q <= '0;
        end else if (line_tick) begin
            ph_q <= cls;
            if (cls == ph_q) begin
                if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= CNT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        emit_valid  = line_tick && (cls != ph_q);
        emit_phase  = ph_q;
        emit_count  = cnt_q;
        emit_sync   = (cnt_q > SYN_CAP) ? SYN_W'(SYN_CAP) : cnt_q[SYN_W-1:0];
        field_start = line_tick && (cls == PH_SYNC) && (ph_q != PH_SYNC);
    end

    p_cnt_saturates_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tick && cls == ph_q && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
    p_front_needs_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tick && ph_q == PH_BACK && !vsync && !vactive) |=> (ph_q == PH_BACK));
endmodule

// File: rtl/vtm_field_track.sv
module vtm_field_track
    import vtm_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int SYN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             emit_valid,
    input  phase_e           emit_phase,
    input  logic [CNT_W-1:0] emit_count,
    input  logic [SYN_W-1:0] emit_sync,
    input  logic             field_start,
    input  logic             vd_rst,
    output logic [SYN_W-1:0] prev_sync,
    output logic [CNT_W-1:0] prev_back,
    output logic [CNT_W-1:0] prev_front
);
    logic [SYN_W-1:0] fld_sync, nxt_sync;
    logic [CNT_W-1:0] fld_back, nxt_back, fld_front, nxt_front;

    always_comb begin
        nxt_sync  = (emit_valid && emit_phase == PH_SYNC)  ? emit_sync  : fld_sync;
        nxt_back  = (emit_valid && emit_phase == PH_BACK)  ? emit_count : fld_back;
        nxt_front = (emit_valid && emit_phase == PH_FRONT) ? emit_count : fld_front;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || vd_rst) begin
            fld_sync   <= '0;
            fld_back   <= '0;
            fld_front  <= '0;
            prev_sync  <= '0;
            prev_back  <= '0;
            prev_front <= '0;
        end else if (field_start) begin
            prev_sync  <= nxt_sync;
            prev_back  <= nxt_back;
            prev_front <= nxt_front;
            fld_sync   <= '0;
            fld_back   <= '0;
            fld_front  <= '0;
        end else begin
            fld_sync  <= nxt_sync;
            fld_back  <= nxt_back;
            fld_front <= nxt_front;
        end
    end

    p_shadow_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vd_rst |=> (prev_sync == '0 && prev_back == '0 && prev_front == '0));
    p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!field_start && !vd_rst) |=> ($stable(prev_back) && $stable(prev_front) && $stable(prev_sync)));
endmodule

// File: rtl/vtm_min_ctrl.sv
module vtm_min_ctrl
    import vtm_pkg::*;
#(
    parameter int CNT_W      = 11,
    parameter int SYN_W      = 8,
    parameter int NUM_FIELDS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             emit_valid,
    input  phase_e           emit_phase,
    input  logic [CNT_W-1:0] emit_count,
    input  logic [SYN_W-1:0] emit_sync,
    input  logic             field_start,
    output logic             busy,
    output logic             done,
    output logic [SYN_W-1:0] cur_sync,
    output logic [CNT_W-1:0] cur_back,
    output logic [CNT_W-1:0] cur_front
);
    localparam int FC_W = $clog2(NUM_FIELDS + 1);
    localparam logic [FC_W-1:0] FC_LAST = FC_W'(NUM_FIELDS - 1);

    ctl_e            st_q, st_d;
    logic [FC_W-1:0] fcnt_q;
    logic            last_field;

    assign last_field = field_start && (fcnt_q == FC_LAST);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CT_IDLE: if (start) st_d = CT_ARM;
            CT_ARM:  if (!start && field_start) st_d = CT_RUN;
            CT_RUN:  if (start) st_d = CT_ARM;
                     else if (last_field) st_d = CT_IDLE;
            default: st_d = CT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= CT_IDLE;
            fcnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == CT_ARM) fcnt_q <= '0;
            else if (st_q == CT_RUN && field_start) fcnt_q <= fcnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            cur_sync  <= '1;
            cur_back  <= '1;
            cur_front <= '1;
            done      <= 1'b0;
        end else if (st_q == CT_RUN) begin
            if (emit_valid && emit_phase == PH_SYNC && emit_sync < cur_sync) cur_sync <= emit_sync;
            if (emit_valid && emit_phase == PH_BACK && emit_count < cur_back) cur_back <= emit_count;
            if (emit_valid && emit_phase == PH_FRONT && emit_count < cur_front) cur_front <= emit_count;
            if (last_field) done <= 1'b1;
        end
    end

    assign busy = (st_q != CT_IDLE);

    p_done_on_finish_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    p_min_never_rises_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (cur_back <= $past(cur_back) && cur_front <= $past(cur_front) && cur_sync <= $past(cur_sync)));
    p_start_rearms_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !done && cur_back == '1 && cur_sync == '1));
endmodule

// File: rtl/vtm_regif.sv
module vtm_regif #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 11,
    parameter int SYN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              start,
    output logic              vd_rst,
    input  logic              busy,
    input  logic              done,
    input  logic [SYN_W-1:0]  cur_sync,
    input  logic [CNT_W-1:0]  cur_back,
    input  logic [CNT_W-1:0]  cur_front,
    input  logic [SYN_W-1:0]  prev_sync,
    input  logic [CNT_W-1:0]  prev_back,
    input  logic [CNT_W-1:0]  prev_front
);
    localparam int HI_W = CNT_W - DATA_W;
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CSYN  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_CB_LO = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_CB_HI = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_CF_LO = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_CF_HI = ADDR_W'(5);
    localparam logic [ADDR_W-1:0] A_PSYN  = ADDR_W'(6);
    localparam logic [ADDR_W-1:0] A_PB_LO = ADDR_W'(7);
    localparam logic [ADDR_W-1:0] A_PB_HI = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] A_PF_LO = ADDR_W'(9);
    localparam logic [ADDR_W-1:0] A_PF_HI = ADDR_W'(10);

    logic [DATA_W-1:0] rd_val;
    logic [HI_W-1:0]   hold_q, latch_val;
    logic              latch_en, is_hi;
    logic              unused_wdata;

    assign start        = bus_wr && (bus_addr == A_CTRL) && bus_wdata[0];
    assign vd_rst       = bus_wr && (bus_addr == A_CTRL) && bus_wdata[2];
    assign unused_wdata = ^{bus_wdata[DATA_W-1:3], bus_wdata[1]};
    assign is_hi        = (bus_addr == A_CB_HI) || (bus_addr == A_CF_HI) ||
                          (bus_addr == A_PB_HI) || (bus_addr == A_PF_HI);

    always_comb begin
        rd_val    = '0;
        latch_en  = 1'b0;
        latch_val = '0;
        case (bus_addr)
            A_CTRL:  rd_val = DATA_W'({done, busy});
            A_CSYN:  rd_val = DATA_W'(cur_sync);
            A_PSYN:  rd_val = DATA_W'(prev_sync);
            A_CB_LO: begin rd_val = cur_back[DATA_W-1:0];   latch_en = 1'b1; latch_val = cur_back[CNT_W-1:DATA_W];   end
            A_CF_LO: begin rd_val = cur_front[DATA_W-1:0];  latch_en = 1'b1; latch_val = cur_front[CNT_W-1:DATA_W];  end
            A_PB_LO: begin rd_val = prev_back[DATA_W-1:0];  latch_en = 1'b1; latch_val = prev_back[CNT_W-1:DATA_W];  end
            A_PF_LO: begin rd_val = prev_front[DATA_W-1:0]; latch_en = 1'b1; latch_val = prev_front[CNT_W-1:DATA_W]; end
            A_CB_HI, A_CF_HI, A_PB_HI, A_PF_HI: rd_val = DATA_W'(hold_q);
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            hold_q    <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_val;
            if (latch_en) hold_q <= latch_val;
        end
    end

    p_hi_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && is_hi) |=> (bus_rdata[DATA_W-1:HI_W] == '0));
    p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr > A_PF_HI) |=> (bus_rdata == '0));
endmodule

// File: rtl/vert_timing_meas.sv
module vert_timing_meas
    import vtm_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 8,
    parameter int CNT_W      = 11,
    parameter int SYN_W      = 8,
    parameter int NUM_FIELDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_tick,
    input  logic              vsync,
    input  logic              vactive,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    logic             emit_valid, field_start, start, vd_rst, busy, done;
    phase_e           emit_phase;
    logic [CNT_W-1:0] emit_count, cur_back, cur_front, prev_back, prev_front;
    logic [SYN_W-1:0] emit_sync, cur_sync, prev_sync;

    vtm_line_classifier #(.CNT_W(CNT_W), .SYN_W(SYN_W)) u_cls (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .vsync(vsync), .vactive(vactive),
        .emit_valid(emit_valid), .emit_phase(emit_phase), .emit_count(emit_count),
        .emit_sync(emit_sync), .field_start(field_start));

    vtm_field_track #(.CNT_W(CNT_W), .SYN_W(SYN_W)) u_prev (
        .clk(clk), .rst_n(rst_n), .emit_valid(emit_valid), .emit_phase(emit_phase),
        .emit_count(emit_count), .emit_sync(emit_sync), .field_start(field_start),
        .vd_rst(vd_rst), .prev_sync(prev_sync), .prev_back(prev_back), .prev_front(prev_front));

    vtm_min_ctrl #(.CNT_W(CNT_W), .SYN_W(SYN_W), .NUM_FIELDS(NUM_FIELDS)) u_ctl (
        .clk(clk), .rst_n(rst_n), .start(start), .emit_valid(emit_valid),
        .emit_phase(emit_phase), .emit_count(emit_count), .emit_sync(emit_sync),
        .field_start(field_start), .busy(busy), .done(done),
        .cur_sync(cur_sync), .cur_back(cur_back), .cur_front(cur_front));

    vtm_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .SYN_W(SYN_W)) u_reg (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .start(start), .vd_rst(vd_rst),
        .busy(busy), .done(done), .cur_sync(cur_sync), .cur_back(cur_back),
        .cur_front(cur_front), .prev_sync(prev_sync), .prev_back(prev_back),
        .prev_front(prev_front));
endmodule

// File: tb/sim_vert_timing_meas.sv
`timescale 1ns/1ps
module sim_vert_timing_meas;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_tick = 1'b0, vsync = 1'b0, vactive = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    int         n_chk = 0, n_fail = 0;
    bit         finished = 1'b0;

    always #4 clk = ~clk;

    vert_timing_meas u0 (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .vsync(vsync), .vactive(vactive),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata));

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic send_lines(input int n, input logic vs, input logic va);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            vsync = vs; vactive = va; line_tick = 1'b1;
            @(negedge clk);
            line_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic send_field(input int s, input int b, input int a, input int f);
        send_lines(s, 1'b1, 1'b0);
        send_lines(b, 1'b0, 1'b0);
        send_lines(a, 1'b0, 1'b1);
        send_lines(f, 1'b0, 1'b0);
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic expect_reg(input string tag, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] d;
        reg_read(a, d);
        check(tag, d, exp);
    endtask

    task automatic t_reset;
        expect_reg("R5 reset ctrl", 4'd0, 8'h00);
        expect_reg("R8 reset prev sync", 4'd6, 8'h00);
        expect_reg("R8 reset prev back lo", 4'd7, 8'h00);
        expect_reg("R10 reset cur back lo", 4'd2, 8'hFF);
        expect_reg("R10 reset cur back hi", 4'd3, 8'h07);
    endtask

    task automatic t_measure_run;
        reg_write(4'd0, 8'h01);
        send_lines(2, 1'b0, 1'b0);            // partial back porch before arming (R6)
        send_field(3, 10, 20, 5);
        send_field(4, 9, 20, 6);
        expect_reg("R6 busy mid run", 4'd0, 8'h01);
        send_field(3, 12, 20, 4);
        send_field(5, 11, 20, 7);
        expect_reg("R6 still busy before last field start", 4'd0, 8'h01);
        send_lines(1, 1'b1, 1'b0);
        expect_reg("R6 self-clear and done", 4'd0, 8'h02);
        expect_reg("R7 min sync", 4'd1, 8'd3);
        expect_reg("R7 R6 min back lo", 4'd2, 8'd9);
        expect_reg("R7 min back hi", 4'd3, 8'd0);
        expect_reg("R7 min front lo", 4'd4, 8'd4);
        expect_reg("R7 min front hi", 4'd5, 8'd0);
        expect_reg("R1 R8 prev sync", 4'd6, 8'd5);
        expect_reg("R2 R8 prev back lo", 4'd7, 8'd11);
        expect_reg("R3 R8 prev front lo", 4'd9, 8'd7);
        expect_reg("R10 prev front hi", 4'd10, 8'd0);
    endtask

    task automatic t_rearm;
        reg_write(4'd0, 8'h01);
        expect_reg("R5 rearm ctrl", 4'd0, 8'h01);
        expect_reg("R5 rearm sync", 4'd1, 8'hFF);
        expect_reg("R5 rearm back lo", 4'd2, 8'hFF);
        expect_reg("R5 rearm back hi", 4'd3, 8'h07);
        expect_reg("R5 rearm front lo", 4'd4, 8'hFF);
    endtask

    task automatic t_saturate_and_latch;
        send_lines(300, 1'b1, 1'b0);
        send_lines(2100, 1'b0, 1'b0);
        send_lines(1, 1'b1, 1'b0);
        expect_reg("R4 sync saturates", 4'd6, 8'd255);
        expect_reg("R8 no video front zero", 4'd9, 8'd0);
        expect_reg("R4 back saturates lo", 4'd7, 8'hFF);
        reg_write(4'd0, 8'h04);
        expect_reg("R10 hi latched across change", 4'd8, 8'h07);
        expect_reg("R9 cleared back lo", 4'd7, 8'h00);
        expect_reg("R9 cleared back hi", 4'd8, 8'h00);
    endtask

    task automatic t_no_video_total;
        logic [7:0] s, b;
        send_lines(5, 1'b1, 1'b0);
        send_lines(94, 1'b0, 1'b0);
        send_lines(1, 1'b1, 1'b0);
        reg_read(4'd6, s);
        reg_read(4'd7, b);
        check("R11 back plus sync equals 100 lines", s + b, 8'd100);
        reg_write(4'd0, 8'h04);
        expect_reg("R9 clear prev sync", 4'd6, 8'h00);
        expect_reg("R9 clear prev back", 4'd7, 8'h00);
        expect_reg("R9 clear prev front", 4'd9, 8'h00);
        expect_reg("R12 unmapped addr 11", 4'd11, 8'h00);
        expect_reg("R12 unmapped addr 15", 4'd15, 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_measure_run();
        t_rearm();
        t_saturate_and_latch();
        t_no_video_total();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R6 actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule